// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable target for a two-wire serial bus that presents a 4096 x 8 byte-wide nonvolatile memory. It sits behind a pad pair driven in open-drain fashion. It samples the clock line and the data line through synchronizers clocked by the system clock. It pulls the data line low by raising an output-enable, and the value it drives is always zero. Three strap inputs set its chip-select code, so as many as eight of these targets can share one bus.

A host writes by sending a control byte, a two-byte word address and one or more data bytes. The data bytes land in a 32-byte page buffer. The buffer is copied into the array only when a STOP arrives. That copy runs as an internal programming cycle with a length set in clock cycles. During the cycle the target refuses its own control byte, so the host can poll for completion. Reads come in three forms. A current read starts from the internal pointer. A random read first sends a dummy write of the word address and then a repeated START. A sequential read goes on for as long as the host acknowledges. A write-protect input stops any programming cycle from starting and leaves reads working.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges a control byte only when its upper four bits are 1010 and bits 3..1 equal the strap inputs. Bit 0 selects read (1) or write (0). On a mismatch it leaves the data line released for that byte and for every later byte until the next START or STOP.
- R2: The word address comes as two bytes, high byte first. Only the low four bits of the high byte are used, and its upper four bits have no effect.
- R3: Written data reaches the array only after a STOP that ends a write with at least one data byte. A byte written and then read back at the same word address returns that byte.
- R4: During a write, only the low five address bits advance after each data byte. Bytes beyond the end of a 32-byte page wrap to the start of the same page and overwrite the bytes loaded earlier. No location outside that page changes.
- R5: While a programming cycle runs (WR_CYCLES clocks after the STOP), a control byte gets no acknowledge. After the cycle ends it is acknowledged again.
- R6: While the write-protect input is high at the STOP, no programming cycle starts and the array is unchanged. The next control byte is acknowledged at once, and reads return the stored data.
- R7: A repeated START in the middle of a write abandons the buffered bytes without programming. A random read of the form dummy write plus repeated START returns the byte at the given address.
- R8: During a read, the pointer advances after every byte across the whole 12-bit space, wrapping from 0xFFF to 0x000. Reading continues until the host answers a byte with a NACK.
- R9: A current read with no address phase returns the byte one past the last byte read.
- R10: While reset is asserted, and right after it, the data line is released (output-enable low).
- R11: A STOP that follows the word address with no data byte starts no programming cycle, so the next control byte is acknowledged at once.
- R12: The target changes its data-line output-enable only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, sampling the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Value driven on the data line when enabled (constant 0) |
| sda_oe | output | 1 | Data-line drive enable; high pulls the line low |
| strap_i | input | 3 | Chip-select straps compared with control-byte bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks programming cycles |

## Verification
The page test loads 34 bytes into one page and checks the first two locations. A design that let the pointer carry into the next page would corrupt the neighbour page, and one that stopped at 32 bytes would keep the old first bytes. The wrap checks cover both that case and a write that starts near the end of a page. The busy test polls straight after a STOP and expects a NACK followed by a later ACK. A target that acknowledged during programming, or that never left the busy state, fails here. Protected writes, STOPs after only the address and repeated STARTs after data are each followed by an immediate poll and a readback, which catches any spurious programming cycle. A sequential read across 0xFFF shows whether the read pointer wraps over the full address space rather than within a page.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    CX_IDLE,
    CX_CTRL,
    CX_AHI,
    CX_ALO,
    CX_WDATA,
    CX_READ
  } ctx_e;

  typedef enum logic [1:0] {
    PH_RX,
    PH_ACKO,
    PH_TX,
    PH_ACKI
  } phase_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_q, sda_q;
  logic [STAGES-1:0] scl_n, sda_n;
  logic              scl_d, sda_d;

  generate
    if (STAGES > 1) begin : g_chain
      assign scl_n = {scl_q[STAGES-2:0], scl_i};
      assign sda_n = {sda_q[STAGES-2:0], sda_i};
    end else begin : g_single
      assign scl_n = scl_i;
      assign sda_n = sda_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= scl_n;
      sda_q <= sda_n;
      scl_d <= scl_q[LAST];
      sda_d <= sda_q[LAST];
    end
  end

  assign scl_s    = scl_q[LAST];
  assign sda_s    = sda_q[LAST];
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 625000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clr,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy,
  output logic                     arr_we
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] LAST_IDX = PAGE_W'(PAGE - 1);
  localparam logic [TW-1:0]     TMR_INIT = TW'(WR_CYCLES);

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pmask, pmask_n;
  logic [TW-1:0]     tmr, tmr_n;
  logic              copying, copying_n;
  logic [PAGE_W-1:0] cidx, cidx_n;
  logic [PG_W-1:0]   page_q, page_n;

  always_comb begin
    pmask_n   = pmask;
    tmr_n     = tmr;
    copying_n = copying;
    cidx_n    = cidx;
    page_n    = page_q;
    if (buf_clr) pmask_n = '0;
    if (buf_we)  pmask_n[buf_idx] = 1'b1;
    if (tmr != '0) tmr_n = tmr - TW'(1);
    if (copying) begin
      cidx_n = cidx + PAGE_W'(1);
      if (cidx == LAST_IDX) copying_n = 1'b0;
    end
    if (commit) begin
      tmr_n     = TMR_INIT;
      copying_n = 1'b1;
      cidx_n    = '0;
      page_n    = commit_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask   <= '0;
      tmr     <= '0;
      copying <= 1'b0;
      cidx    <= '0;
      page_q  <= '0;
    end else begin
      pmask   <= pmask_n;
      tmr     <= tmr_n;
      copying <= copying_n;
      cidx    <= cidx_n;
      page_q  <= page_n;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  assign arr_we = copying & pmask[cidx];

  always_ff @(posedge clk) begin
    if (arr_we) mem[{page_q, cidx}] <= pbuf[cidx];
  end

  assign rd_data = mem[rd_addr];
  assign busy    = (tmr != '0);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int WR_CYCLES   = 625000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import eep_pkg::*;

  localparam int HI_W = ADDR_W - 8;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  ctx_e            ctx, ctx_n;
  phase_e          phase, phase_n;
  logic [3:0]      bitcnt, bitcnt_n;
  logic [7:0]      shreg, shreg_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic [HI_W-1:0] ahi, ahi_n;
  logic            oe, oe_n;
  logic            rw, rw_n;
  logic            wrote, wrote_n;

  logic            buf_clr, buf_we, commit_go, ack_ctrl;
  logic [7:0]      rd_data;
  logic            busy, arr_we;
  logic            ctrl_match;

  assign ctrl_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_i) && !busy;

  always_comb begin
    ctx_n     = ctx;
    phase_n   = phase;
    bitcnt_n  = bitcnt;
    shreg_n   = shreg;
    ptr_n     = ptr;
    ahi_n     = ahi;
    oe_n      = oe;
    rw_n      = rw;
    wrote_n   = wrote;
    buf_clr   = 1'b0;
    buf_we    = 1'b0;
    commit_go = 1'b0;
    ack_ctrl  = 1'b0;

    if (start_p) begin
      ctx_n    = CX_CTRL;
      phase_n  = PH_RX;
      bitcnt_n = '0;
      oe_n     = 1'b0;
      wrote_n  = 1'b0;
    end else if (stop_p) begin
      if (ctx == CX_WDATA && wrote && !wp_i) commit_go = 1'b1;
      ctx_n   = CX_IDLE;
      phase_n = PH_RX;
      oe_n    = 1'b0;
      wrote_n = 1'b0;
    end else if (ctx != CX_IDLE) begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg_n  = {shreg[6:0], sda_s};
            bitcnt_n = bitcnt + 4'd1;
          end
          if (scl_fall && bitcnt == 4'd8) begin
            unique case (ctx)
              CX_CTRL: begin
                if (ctrl_match) begin
                  ack_ctrl = 1'b1;
                  rw_n     = shreg[0];
                  phase_n  = PH_ACKO;
                  oe_n     = 1'b1;
                end else begin
                  ctx_n = CX_IDLE;
                end
              end
              CX_AHI: begin
                ahi_n   = shreg[HI_W-1:0];
                phase_n = PH_ACKO;
                oe_n    = 1'b1;
              end
              CX_ALO: begin
                ptr_n   = {ahi, shreg};
                buf_clr = 1'b1;
                phase_n = PH_ACKO;
                oe_n    = 1'b1;
              end
              CX_WDATA: begin
                buf_we  = 1'b1;
                ptr_n   = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                wrote_n = 1'b1;
                phase_n = PH_ACKO;
                oe_n    = 1'b1;
              end
              default: ctx_n = CX_IDLE;
            endcase
          end
        end
        PH_ACKO: begin
          if (scl_fall) begin
            bitcnt_n = '0;
            oe_n     = 1'b0;
            phase_n  = PH_RX;
            unique case (ctx)
              CX_CTRL: begin
                if (rw) begin
                  ctx_n   = CX_READ;
                  phase_n = PH_TX;
                  shreg_n = rd_data;
                  ptr_n   = ptr + ADDR_W'(1);
                  oe_n    = ~rd_data[7];
                end else begin
                  ctx_n = CX_AHI;
                end
              end
              CX_AHI:  ctx_n = CX_ALO;
              CX_ALO:  ctx_n = CX_WDATA;
              default: ctx_n = ctx;
            endcase
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            bitcnt_n = bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              oe_n    = 1'b0;
              phase_n = PH_ACKI;
            end else begin
              shreg_n = {shreg[6:0], 1'b0};
              oe_n    = ~shreg[6];
            end
          end
        end
        PH_ACKI: begin
          if (scl_rise && sda_s) begin
            ctx_n = CX_IDLE;
          end else if (scl_fall) begin
            phase_n  = PH_TX;
            bitcnt_n = '0;
            shreg_n  = rd_data;
            ptr_n    = ptr + ADDR_W'(1);
            oe_n     = ~rd_data[7];
          end
        end
        default: phase_n = PH_RX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx    <= CX_IDLE;
      phase  <= PH_RX;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      ahi    <= '0;
      oe     <= 1'b0;
      rw     <= 1'b0;
      wrote  <= 1'b0;
    end else begin
      ctx    <= ctx_n;
      phase  <= phase_n;
      bitcnt <= bitcnt_n;
      shreg  <= shreg_n;
      ptr    <= ptr_n;
      ahi    <= ahi_n;
      oe     <= oe_n;
      rw     <= rw_n;
      wrote  <= wrote_n;
    end
  end

  eep_store #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .WR_CYCLES (WR_CYCLES)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_clr     (buf_clr),
    .buf_we      (buf_we),
    .buf_idx     (ptr[PAGE_W-1:0]),
    .buf_data    (shreg),
    .commit      (commit_go),
    .commit_page (ptr[ADDR_W-1:PAGE_W]),
    .rd_addr     (ptr),
    .rd_data     (rd_data),
    .busy        (busy),
    .arr_we      (arr_we)
  );

  assign sda_oe = oe;
  assign sda_o  = 1'b0;
endmodule

// File: rtl/eep_chk.sv
module eep_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wp_i,
  input logic busy,
  input logic arr_we,
  input logic ack_ctrl,
  input logic stop_p
);
  // R10
  reset_release_chk: assert property (@(posedge clk) !rst_n |-> !sda_oe)
    else $error("data line driven during reset");

  // R12
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i)
    else $error("data-line drive changed while clock high");

  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ctrl |-> !busy)
    else $error("control byte acknowledged while programming");

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i))
    else $error("programming started under write protect");

  // R3
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_p))
    else $error("programming started without a STOP");

  // R4
  array_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy)
    else $error("array written outside a programming cycle");
endmodule

bind i2c_eeprom_target eep_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .wp_i     (wp_i),
  .busy     (busy),
  .arr_we   (arr_we),
  .ack_ctrl (ack_ctrl),
  .stop_p   (stop_p)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;
  localparam int Q     = 10;
  localparam int WRCYC = 1500;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk, rst_n, m_scl, m_sda, wp;
  logic sda_o, sda_oe, sda_bus;
  int checks, errors, r12_viol;
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [8];

  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_target #(.WR_CYCLES(WRCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic prev_oe;
  always @(negedge clk) begin
    if (rst_n && prev_oe !== sda_oe && m_scl) r12_viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(last);
  endtask

  task automatic wait_ready(output int polls);
    bit ack;
    polls = 0;
    for (int i = 0; i < 40; i++) begin
      bus_start(); send_byte(CW, ack); bus_stop();
      polls++;
      if (ack) break;
    end
  endtask

  task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo, input int n);
    bit ack;
    int p;
    bus_start(); send_byte(CW, ack); send_byte(hi, ack); send_byte(lo, ack);
    for (int i = 0; i < n; i++) send_byte(wbuf[i], ack);
    bus_stop();
    wait_ready(p);
  endtask

  task automatic read_seq(input logic [7:0] hi, input logic [7:0] lo, input int n);
    bit ack;
    bus_start(); send_byte(CW, ack); send_byte(hi, ack); send_byte(lo, ack);
    bus_start(); send_byte(CR, ack);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], (i == n-1));
    bus_stop();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R10 oe after reset", sda_oe, 0);
    check(sda_o == 1'b0, "R10 drive value", sda_o, 0);
  endtask

  task automatic t_match();
    bit ack;
    int p;
    bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, ack);
    check(!ack, "R1 strap mismatch NACK", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R1 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
    check(!ack, "R1 device code mismatch NACK", ack, 0);
    bus_start(); send_byte(CW, ack); bus_stop();
    check(ack, "R1 matching control ACK", ack, 1);
  endtask

  task automatic t_byte_and_busy();
    bit ack;
    int p;
    bus_start(); send_byte(CW, ack); send_byte(8'hF1, ack); send_byte(8'h23, ack);
    send_byte(8'h5A, ack);
    check(ack, "R3 data byte ACK", ack, 1);
    bus_stop();
    bus_start(); send_byte(CW, ack); bus_stop();
    check(!ack, "R5 NACK while programming", ack, 0);
    wait_ready(p);
    check(p >= 1 && p < 40, "R5 ACK after cycle", p, 1);
    read_seq(8'h01, 8'h23, 1);
    check(rbuf[0] == 8'h5A, "R3 readback", rbuf[0], 8'h5A);
    read_seq(8'hA1, 8'h23, 1);
    check(rbuf[0] == 8'h5A, "R2 upper nibble ignored", rbuf[0], 8'h5A);
  endtask

  task automatic t_aborts();
    bit ack;
    bus_start(); send_byte(CW, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
    send_byte(8'h77, ack);
    bus_start(); send_byte(CW, ack); bus_stop();
    check(ack, "R7 repeated START no busy", ack, 1);
    read_seq(8'h01, 8'h23, 1);
    check(rbuf[0] == 8'h5A, "R7 abandoned write and random read", rbuf[0], 8'h5A);
    bus_start(); send_byte(CW, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
    bus_stop();
    bus_start(); send_byte(CW, ack); bus_stop();
    check(ack, "R11 address-only STOP no busy", ack, 1);
  endtask

  task automatic t_page();
    wbuf[0] = 8'h99; write_seq(8'h02, 8'h20, 1);
    wbuf[0] = 8'hAB; write_seq(8'h02, 8'h40, 1);
    for (int i = 0; i < 34; i++) wbuf[i] = 8'(8'h40 + i);
    write_seq(8'h02, 8'h00, 34);
    read_seq(8'h02, 8'h00, 3);
    check(rbuf[0] == 8'h60, "R4 wrap overwrite byte0", rbuf[0], 8'h60);
    check(rbuf[1] == 8'h61, "R4 wrap overwrite byte1", rbuf[1], 8'h61);
    check(rbuf[2] == 8'h42, "R4 byte2 kept", rbuf[2], 8'h42);
    read_seq(8'h02, 8'h1F, 2);
    check(rbuf[0] == 8'h5F, "R4 last page byte", rbuf[0], 8'h5F);
    check(rbuf[1] == 8'h99, "R4 next page untouched", rbuf[1], 8'h99);
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    write_seq(8'h02, 8'h3E, 3);
    read_seq(8'h02, 8'h20, 1);
    check(rbuf[0] == 8'hC3, "R4 mid-page wrap", rbuf[0], 8'hC3);
    read_seq(8'h02, 8'h40, 1);
    check(rbuf[0] == 8'hAB, "R4 following page untouched", rbuf[0], 8'hAB);
  endtask

  task automatic t_wp();
    bit ack;
    wp = 1'b1;
    bus_start(); send_byte(CW, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
    send_byte(8'h11, ack);
    check(ack, "R6 data ACK under protect", ack, 1);
    bus_stop();
    bus_start(); send_byte(CW, ack); bus_stop();
    check(ack, "R6 no busy under protect", ack, 1);
    read_seq(8'h01, 8'h23, 1);
    check(rbuf[0] == 8'h5A, "R6 array unchanged, read works", rbuf[0], 8'h5A);
    wp = 1'b0;
  endtask

  task automatic t_seq_wrap();
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; write_seq(8'h0F, 8'hFE, 2);
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1; write_seq(8'h00, 8'h00, 2);
    read_seq(8'h0F, 8'hFE, 4);
    check(rbuf[0] == 8'hE1, "R8 seq 0xFFE", rbuf[0], 8'hE1);
    check(rbuf[1] == 8'hE2, "R8 seq 0xFFF", rbuf[1], 8'hE2);
    check(rbuf[2] == 8'hD0, "R8 wrap to 0x000", rbuf[2], 8'hD0);
    check(rbuf[3] == 8'hD1, "R8 seq 0x001", rbuf[3], 8'hD1);
  endtask

  task automatic t_current();
    bit ack;
    read_seq(8'h02, 8'h00, 1);
    bus_start(); send_byte(CR, ack);
    check(ack, "R9 current read ACK", ack, 1);
    recv_byte(rbuf[0], 1'b1);
    bus_stop();
    check(rbuf[0] == 8'h61, "R9 current read data", rbuf[0], 8'h61);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; r12_viol = 0; prev_oe = 1'b0;
    m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; rst_n = 1'b0;
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_match();
    t_byte_and_busy();
    t_aborts();
    t_page();
    t_wp();
    t_seq_wrap();
    t_current();
    check(r12_viol == 0, "R12 drive changes only with clock low", r12_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule